// File: doc/BRIEF.md
# Three-Share Masked Bit-Serial Adder

This block adds two words one bit position per clock while every secret value stays split into three XOR shares. Each cycle it takes three shares of operand bit a and three shares of operand bit b, and it returns three shares of the sum bit. The carry between bit positions is kept as three share registers. An n-bit addition modulo 2^n therefore takes n valid cycles, least significant bit first, through one small adder circuit.

The carry is produced by three separate share functions. Each function reads only two of the three shares of a, b and the carry, so no single function ever combines all shares of a secret bit. Every carry share is registered before the next bit uses it. Fresh randomness, splitting words into shares and recombining the result are done outside the block. A word begins with a start flag on its first valid bit. That bit treats the incoming carry as zero in all three shares.

Top module: `masked_serial_adder`

## Requirements
- R1: On every cycle with bitValid high, the XOR of the three sumSh bits equals a ^ b ^ c. Here a is the XOR of the aSh bits, b is the XOR of the bSh bits, and c is the recombined incoming carry, which is zero when wordStart is high.
- R2: Bit j of sumSh (j = 0, 1, 2) is aSh[j] ^ bSh[j] ^ cj, where cj is carry share j coming into the cycle.
- R3: After a valid cycle, the XOR of the three stored carry shares equals the majority of a, b and the incoming carry c of that cycle.
- R4: Carry share j is computed only from the shares with indices (j+1) mod 3 and (j+2) mod 3. Naming those indices p and q, the share is ap&bp ^ ap&bq ^ aq&bp ^ ap&cp ^ ap&cq ^ aq&cp ^ bp&cp ^ bp&cq ^ bq&cp.
- R5: wordStart is only acted on when bitValid is high. In that cycle all three incoming carry shares are taken as zero, so sumSh = aSh ^ bSh, whatever carry the previous word left behind.
- R6: A cycle with bitValid low leaves the carry shares unchanged, and wordStart has no effect in that cycle.
- R7: Feeding the bits of words A and B from least significant upward, with wordStart on bit 0, yields the recombined sum bits of (A + B) mod 2^n. The carry out of the top bit is dropped.
- R8: After reset all carry shares are zero. A valid bit without wordStart as the first bit after reset therefore sees a zero carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wordStart | input | 1 | First bit of a new word (qualified by bitValid) |
| bitValid | input | 1 | Operand shares carry a bit position this cycle |
| aSh | input | 3 | Three XOR shares of operand bit a |
| bSh | input | 3 | Three XOR shares of operand bit b |
| sumSh | output | 3 | Three XOR shares of the sum bit (combinational) |

## Verification
The clear of the carry at a word start and the load of the new carry both fall in the first valid cycle of a word. They collide hardest right after a word whose final carry was one, for example all ones plus one. The bench runs words back to back, so the stale carry and the start bit meet in one cycle. It then checks two things: the sum shares equal the plain operand share XOR, and the carry shares seen in the next bit follow the share formula from zero. Idle cycles with wordStart raised are mixed into words, and the carry seen on the next valid bit must be unchanged.

// File: rtl/masked_add_pkg.sv
package masked_add_pkg;
  localparam int SHARES = 3;

  typedef struct packed {
    logic clearCarry;
    logic loadCarry;
  } addStrobes_t;
endpackage

// File: rtl/masked_add_ctrl.sv
module masked_add_ctrl
  import masked_add_pkg::*;
(
  input  logic        wordStart,
  input  logic        bitValid,
  output addStrobes_t strobes
);
  // a start flag only counts on a valid bit
  always_comb begin
    strobes.loadCarry  = bitValid;
    strobes.clearCarry = bitValid & wordStart;
  end
endmodule

// File: rtl/carry_share_fn.sv
module carry_share_fn (
  input  logic aP,
  input  logic aQ,
  input  logic bP,
  input  logic bQ,
  input  logic cP,
  input  logic cQ,
  output logic cOut
);
  // reads two share indices only; the third is never seen here
  always_comb begin
    cOut = (aP & bP) ^ (aP & bQ) ^ (aQ & bP)
         ^ (aP & cP) ^ (aP & cQ) ^ (aQ & cP)
         ^ (bP & cP) ^ (bP & cQ) ^ (bQ & cP);
  end
endmodule

// File: rtl/masked_add_dp.sv
module masked_add_dp
  import masked_add_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  addStrobes_t       strobes,
  input  logic [SHARES-1:0] aSh,
  input  logic [SHARES-1:0] bSh,
  output logic [SHARES-1:0] sumSh,
  output logic [SHARES-1:0] carryQ
);
  logic [SHARES-1:0] carryIn;
  logic [SHARES-1:0] carryNext;

  assign carryIn = strobes.clearCarry ? '0 : carryQ;

  for (genvar j = 0; j < SHARES; j++) begin : g_share
    localparam int P = (j + 1) % SHARES;
    localparam int Q = (j + 2) % SHARES;

    assign sumSh[j] = aSh[j] ^ bSh[j] ^ carryIn[j];

    carry_share_fn u_carry (
      .aP  (aSh[P]),
      .aQ  (aSh[Q]),
      .bP  (bSh[P]),
      .bQ  (bSh[Q]),
      .cP  (carryIn[P]),
      .cQ  (carryIn[Q]),
      .cOut(carryNext[j])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= '0;
    end else if (strobes.loadCarry) begin
      carryQ <= carryNext;
    end
  end
endmodule

// File: rtl/masked_serial_adder.sv
module masked_serial_adder
  import masked_add_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordStart,
  input  logic       bitValid,
  input  logic [2:0] aSh,
  input  logic [2:0] bSh,
  output logic [2:0] sumSh
);
  addStrobes_t       strobes;
  logic [SHARES-1:0] carryQ;

  masked_add_ctrl u_ctrl (
    .wordStart(wordStart),
    .bitValid (bitValid),
    .strobes  (strobes)
  );

  masked_add_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .aSh    (aSh),
    .bSh    (bSh),
    .sumSh  (sumSh),
    .carryQ (carryQ)
  );
endmodule

// File: rtl/masked_add_checker.sv
module masked_add_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wordStart,
  input logic       bitValid,
  input logic [2:0] aSh,
  input logic [2:0] bSh,
  input logic [2:0] sumSh,
  input logic [2:0] carryQ
);
  logic aBit, bBit, cBit, majBit;
  assign aBit   = ^aSh;
  assign bBit   = ^bSh;
  assign cBit   = wordStart ? 1'b0 : ^carryQ;
  assign majBit = (aBit & bBit) | (aBit & cBit) | (bBit & cBit);

  a_r1_sum_recombine: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (^sumSh) == (aBit ^ bBit ^ cBit));

  a_r2_share_wise: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !wordStart) |-> sumSh == (aSh ^ bSh ^ carryQ));

  a_r3_carry_majority: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> (^carryQ) == $past(majBit));

  a_r5_start_clear: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && wordStart) |-> sumSh == (aSh ^ bSh));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> carryQ == $past(carryQ));

  a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> carryQ == 3'b000);
endmodule

bind masked_serial_adder masked_add_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wordStart(wordStart),
  .bitValid (bitValid),
  .aSh      (aSh),
  .bSh      (bSh),
  .sumSh    (sumSh),
  .carryQ   (carryQ)
);

// File: tb/tb_masked_serial_adder.sv
module tb_masked_serial_adder;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wordStart = 1'b0;
  logic       bitValid = 1'b0;
  logic [2:0] aSh = '0;
  logic [2:0] bSh = '0;
  logic [2:0] sumSh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] prevA, prevB, prevC;
  bit havePrev = 0;
  bit gapBefore = 0;
  bit firstAfterReset = 0;

  always #5 clk = ~clk;

  masked_serial_adder dut (
    .clk(clk), .rstN(rstN), .wordStart(wordStart), .bitValid(bitValid),
    .aSh(aSh), .bSh(bSh), .sumSh(sumSh)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // spec formula of a non-complete carry share, from stated terms
  function automatic logic [2:0] refCarry(input logic [2:0] a, b, c);
    logic [2:0] r;
    for (int j = 0; j < 3; j++) begin
      int p = (j + 1) % 3;
      int q = (j + 2) % 3;
      r[j] = a[p]&b[p] ^ a[p]&b[q] ^ a[q]&b[p] ^ a[p]&c[p] ^ a[p]&c[q]
           ^ a[q]&c[p] ^ b[p]&c[p] ^ b[p]&c[q] ^ b[q]&c[p];
    end
    return r;
  endfunction

  function automatic logic [2:0] split(input logic v);
    logic [2:0] s;
    s[0] = 1'($urandom);
    s[1] = 1'($urandom);
    s[2] = s[0] ^ s[1] ^ v;
    return s;
  endfunction

  task automatic doBit(input logic st, input logic va, input logic aBit,
                       input logic bBit, input logic expCin, output logic gotSum);
    logic [2:0] obsC;
    @(negedge clk);
    wordStart = st;
    bitValid  = va;
    aSh = split(aBit);
    bSh = split(bBit);
    #1;
    obsC   = sumSh ^ aSh ^ bSh;
    gotSum = ^sumSh;
    if (va) begin
      check(gotSum == (aBit ^ bBit ^ expCin), "R1", "recombined sum bit",
            gotSum, aBit ^ bBit ^ expCin);
      check((^obsC) == expCin, "R3", "recombined carry in", ^obsC, expCin);
      if (st) begin
        check(sumSh == (aSh ^ bSh), "R5", "sum shares at word start", sumSh, aSh ^ bSh);
      end else if (firstAfterReset) begin
        check(obsC == 3'b000, "R8", "carry shares after reset", obsC, 0);
      end else if (havePrev) begin
        check(obsC == refCarry(prevA, prevB, prevC), gapBefore ? "R6" : "R4",
              gapBefore ? "carry held over idle" : "carry share functions (R2)",
              obsC, refCarry(prevA, prevB, prevC));
      end
      prevA = aSh; prevB = bSh; prevC = st ? 3'b000 : obsC;
      havePrev = 1; gapBefore = 0; firstAfterReset = 0;
    end else begin
      gapBefore = 1;
    end
  endtask

  task automatic runWord(input logic [N-1:0] A, input logic [N-1:0] B, input bit gaps);
    logic c = 1'b0;
    logic s;
    logic [N-1:0] S;
    logic [N-1:0] expS;
    for (int i = 0; i < N; i++) begin
      doBit(i == 0, 1'b1, A[i], B[i], c, s);
      S[i] = s;
      c = (A[i] & B[i]) | (A[i] & c) | (B[i] & c);
      if (gaps && ($urandom % 2 == 1)) begin
        doBit(1'($urandom), 1'b0, 1'($urandom), 1'($urandom), 1'b0, s);
      end
    end
    expS = A + B;
    check(S == expS, "R7", "word sum", S, expS);
  endtask

  initial begin
    logic s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(sumSh == (aSh ^ bSh), "R8", "sum shares with idle inputs after reset",
          sumSh, aSh ^ bSh);
    firstAfterReset = 1;
    doBit(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, s);
    runWord(16'h0000, 16'h0000, 0);
    runWord(16'hFFFF, 16'h0001, 0);
    runWord(16'h1234, 16'h0F0F, 0);
    runWord(16'hFFFF, 16'hFFFF, 1);
    runWord(16'h8000, 16'h8000, 0);
    runWord(16'hAAAA, 16'h5555, 1);
    for (int k = 0; k < 8; k++) begin
      runWord(16'($urandom), 16'($urandom), k[0]);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule